// File: doc/BRIEF.md
# Strobed Serial Command Interface for an LED Display and Keypad Controller

This block is the serial slave front end of an LED display and keypad controller. A host moves three wires: a strobe, a shift clock and a data line. It reads a fourth wire, the data output, back. All four are sampled into the block's system clock through synchronisers, so the shift clock must be slow next to the system clock. Bits are taken on rising shift-clock edges, least significant bit first. A byte only counts while the strobe is low. The first complete byte after the strobe falls is a command. Later bytes in the same strobe window are either display data or clock cycles that shift key data out.

Four command classes are decoded from bits 7:6 of that first byte. They cover the grid/segment mode, the data-transfer setting, the display address, and on/off plus dimming. Display data goes into a 14-byte memory, which a scan engine reads through a separate asynchronous read port. For key reads the block takes a snapshot of a parallel key vector and shifts it out one bit per falling shift-clock edge. The open-drain pad is represented by a data bit plus an output-enable.

Top module: `scif_top`

## Requirements
- R1: After reset the outputs are: gridSeven=1, dispEnable=0, dimLevel=0, readSel=0, fixedAddr=0, curAddr=0 and serOutEn=0.
- R2: Serial bytes are assembled least significant bit first from serDat at rising serClk edges. While serStb is high, serClk edges have no effect on any register.
- R3: If serStb rises before the eighth bit of a byte, the partial byte is dropped and the next strobe window starts again at bit 0.
- R4: A command with bits 7:6 = 00 sets the grid mode from bit 0 (1 = seven grids/eleven segments, 0 = six grids/twelve segments); bits 5:1 are ignored. A new mode value clears dispEnable. Repeating the current value changes nothing.
- R5: A command with bits 7:6 = 01 is a data setting. Bit 1 selects read (1) or write (0) and shows on readSel. Bit 2 selects a fixed address (1) or auto-increment (0) and shows on fixedAddr. Bits 5:4 are ignored.
- R6: A command with bits 7:6 = 11 loads curAddr from bits 3:0.
- R7: A command with bits 7:6 = 10 sets dispEnable from bit 3 and dimLevel from bits 2:0, so 80h turns the display off at level 0.
- R8: In write mode, each byte after the command in the same strobe window is stored at curAddr. curAddr then increments unless fixed-address mode is selected.
- R9: While curAddr is 0Eh or higher, data bytes are discarded and curAddr holds. Incrementing past 0Dh therefore stops at 0Eh instead of wrapping.
- R10: After a read-selecting data command, the key vector is captured. Its bits go out on serOut from bit 0 upward, each one updated after a falling serClk edge. serOutEn is high only in that read phase and drops once serStb is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock from host |
| serDat | input | 1 | Serial data from host |
| serStb | input | 1 | Serial strobe, active low window |
| keyData | input | KEY_BYTES*8 | Parallel key state, bit 0 shifted first |
| dispRdAddr | input | 4 | Display memory read address for scan logic |
| dispRdData | output | 8 | Display memory read data (0 for out-of-range address) |
| serOut | output | 1 | Serial read data bit |
| serOutEn | output | 1 | Output enable for the open-drain serial read pad |
| gridSeven | output | 1 | 1 = seven-grid/eleven-segment, 0 = six-grid/twelve-segment |
| dispEnable | output | 1 | Display on |
| dimLevel | output | 3 | Dimming (pulse-width) level |
| readSel | output | 1 | Data setting selects key read |
| fixedAddr | output | 1 | Data setting selects fixed address |
| curAddr | output | 4 | Current display address |

## Verification
The bench builds the block with its default parameters: 14 memory bytes, 5 key bytes and 2 synchroniser stages. A 14-byte memory with a 4-bit address field leaves codes 0Eh and 0Fh out of range. This lets the bench test a direct out-of-range address load, and a burst that starts at 0Ch and runs off the end without wrapping back to byte 0. With five key bytes, a 16-bit read crosses a byte boundary in the snapshot.

// File: rtl/scif_pkg.sv
package scif_pkg;
  localparam int ADDR_W = 4;

  localparam logic [1:0] CLS_MODE = 2'b00;
  localparam logic [1:0] CLS_DATA = 2'b01;
  localparam logic [1:0] CLS_CTRL = 2'b10;
  localparam logic [1:0] CLS_ADDR = 2'b11;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_WRITE,
    PH_READ,
    PH_DROP
  } scifPhase_t;

  typedef struct packed {
    logic       setMode;
    logic       setData;
    logic       setAddr;
    logic       setCtrl;
    logic       wrByte;
    logic       startRead;
    logic       shiftOut;
    logic       readActive;
    logic [7:0] byteVal;
  } scifStrb_t;
endpackage

// File: rtl/scif_sync.sv
module scif_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/scif_ctrl.sv
module scif_ctrl
  import scif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclkS,
  input  logic      sdatS,
  input  logic      stbS,
  input  logic      readModeIn,
  output scifStrb_t strb
);
  logic       sclkD;
  logic [2:0] bitCnt;
  logic [6:0] shReg;
  scifPhase_t phase, cmdPhase;
  logic       sclkRise, sclkFall;
  logic [7:0] fullByte;
  logic       nextRead;
  logic       pMode, pData, pAddr, pCtrl, pWr, pStart, pShift;
  logic [7:0] byteReg;

  assign sclkRise = sclkS & ~sclkD;
  assign sclkFall = ~sclkS & sclkD;
  assign fullByte = {sdatS, shReg};

  // phase that follows a command byte
  always_comb begin
    nextRead = (fullByte[7:6] == CLS_DATA) ? fullByte[1] : readModeIn;
    if (!nextRead)                        cmdPhase = PH_WRITE;
    else if (fullByte[7:6] == CLS_DATA)   cmdPhase = PH_READ;
    else                                  cmdPhase = PH_DROP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkD   <= 1'b0;
      bitCnt  <= '0;
      shReg   <= '0;
      phase   <= PH_CMD;
      byteReg <= '0;
      {pMode, pData, pAddr, pCtrl, pWr, pStart, pShift} <= '0;
    end else begin
      sclkD <= sclkS;
      {pMode, pData, pAddr, pCtrl, pWr, pStart, pShift} <= '0;
      if (stbS) begin
        bitCnt <= '0;
        shReg  <= '0;
        phase  <= PH_CMD;
      end else if (sclkRise && phase != PH_READ) begin
        shReg  <= fullByte[7:1];
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          byteReg <= fullByte;
          unique case (phase)
            PH_CMD: begin
              pMode  <= (fullByte[7:6] == CLS_MODE);
              pData  <= (fullByte[7:6] == CLS_DATA);
              pAddr  <= (fullByte[7:6] == CLS_ADDR);
              pCtrl  <= (fullByte[7:6] == CLS_CTRL);
              pStart <= (cmdPhase == PH_READ);
              phase  <= cmdPhase;
            end
            PH_WRITE: pWr <= 1'b1;
            default: ;
          endcase
        end
      end else if (sclkFall && phase == PH_READ) begin
        pShift <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.setMode    = pMode;
    strb.setData    = pData;
    strb.setAddr    = pAddr;
    strb.setCtrl    = pCtrl;
    strb.wrByte     = pWr;
    strb.startRead  = pStart;
    strb.shiftOut   = pShift;
    strb.readActive = (phase == PH_READ);
    strb.byteVal    = byteReg;
  end
endmodule

// File: rtl/scif_datapath.sv
module scif_datapath
  import scif_pkg::*;
#(
  parameter int MEM_DEPTH = 14,
  parameter int KEY_BYTES = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  scifStrb_t              strb,
  input  logic [KEY_BYTES*8-1:0] keyData,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [7:0]             rdData,
  output logic                   dout,
  output logic                   doutEn,
  output logic                   gridSeven,
  output logic                   dispOn,
  output logic [2:0]             dim,
  output logic                   readSel,
  output logic                   fixedAddr,
  output logic [ADDR_W-1:0]      curAddr
);
  localparam int KEY_BITS = KEY_BYTES * 8;
  localparam logic [ADDR_W:0] DEPTH_LIM = (ADDR_W+1)'(MEM_DEPTH);

  logic [7:0]          mem [MEM_DEPTH];
  logic [3:0]          dataCfg;
  logic [KEY_BITS-1:0] keySnap;
  logic                addrValid;

  assign addrValid = {1'b0, curAddr} < DEPTH_LIM;
  assign readSel   = dataCfg[1];
  assign fixedAddr = dataCfg[2];
  assign doutEn    = strb.readActive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gridSeven <= 1'b1;
      dispOn    <= 1'b0;
      dim       <= '0;
      dataCfg   <= '0;
      curAddr   <= '0;
    end else begin
      if (strb.setMode && strb.byteVal[0] != gridSeven) begin
        gridSeven <= strb.byteVal[0];
        dispOn    <= 1'b0;
      end
      if (strb.setData) dataCfg <= strb.byteVal[3:0];
      if (strb.setAddr) curAddr <= strb.byteVal[ADDR_W-1:0];
      if (strb.setCtrl) begin
        dispOn <= strb.byteVal[3];
        dim    <= strb.byteVal[2:0];
      end
      if (strb.wrByte && addrValid && !dataCfg[2]) curAddr <= curAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrByte && addrValid) mem[curAddr] <= strb.byteVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keySnap <= '0;
      dout    <= 1'b0;
    end else if (strb.startRead) begin
      keySnap <= keyData;
      dout    <= 1'b0;
    end else if (strb.shiftOut) begin
      dout    <= keySnap[0];
      keySnap <= {1'b0, keySnap[KEY_BITS-1:1]};
    end
  end

  always_comb begin
    if ({1'b0, rdAddr} < DEPTH_LIM) rdData = mem[rdAddr];
    else                            rdData = '0;
  end
endmodule

// File: rtl/scif_top.sv
module scif_top
  import scif_pkg::*;
#(
  parameter int MEM_DEPTH   = 14,
  parameter int KEY_BYTES   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   serClk,
  input  logic                   serDat,
  input  logic                   serStb,
  input  logic [KEY_BYTES*8-1:0] keyData,
  input  logic [3:0]             dispRdAddr,
  output logic [7:0]             dispRdData,
  output logic                   serOut,
  output logic                   serOutEn,
  output logic                   gridSeven,
  output logic                   dispEnable,
  output logic [2:0]             dimLevel,
  output logic                   readSel,
  output logic                   fixedAddr,
  output logic [3:0]             curAddr
);
  logic [2:0] pinSync;
  logic       stbSync;
  scifStrb_t  strb;

  scif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .din({serStb, serDat, serClk}),
    .dout(pinSync)
  );

  assign stbSync = pinSync[2];

  scif_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .sclkS(pinSync[0]), .sdatS(pinSync[1]), .stbS(stbSync),
    .readModeIn(readSel),
    .strb(strb)
  );

  scif_datapath #(.MEM_DEPTH(MEM_DEPTH), .KEY_BYTES(KEY_BYTES)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .keyData(keyData),
    .rdAddr(dispRdAddr), .rdData(dispRdData),
    .dout(serOut), .doutEn(serOutEn),
    .gridSeven(gridSeven), .dispOn(dispEnable), .dim(dimLevel),
    .readSel(readSel), .fixedAddr(fixedAddr), .curAddr(curAddr)
  );
endmodule

// File: rtl/scif_checker.sv
module scif_checker
  import scif_pkg::*;
#(
  parameter int MEM_DEPTH = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stbS,
  input scifStrb_t  strb,
  input logic       serOutEn,
  input logic [3:0] curAddr,
  input logic       fixedAddr,
  input logic       gridSeven,
  input logic       dispEnable
);
  localparam logic [4:0] LIM = 5'(MEM_DEPTH);

  p_oe_off_strobe_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stbS |=> !serOutEn);

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrByte && !fixedAddr && ({1'b0, curAddr} < LIM)) |=> curAddr == $past(curAddr) + 4'd1);

  p_addr_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrByte && fixedAddr) |=> curAddr == $past(curAddr));

  p_addr_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrByte && ({1'b0, curAddr} >= LIM)) |=> curAddr == $past(curAddr));

  p_mode_change_blanks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setMode && strb.byteVal[0] != gridSeven) |=> (!dispEnable && gridSeven != $past(gridSeven)));

  p_mode_repeat_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setMode && strb.byteVal[0] == gridSeven && !strb.setCtrl) |=> ($stable(dispEnable) && $stable(gridSeven)));
endmodule

bind scif_top scif_checker #(.MEM_DEPTH(MEM_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .stbS(stbSync), .strb(strb),
  .serOutEn(serOutEn), .curAddr(curAddr), .fixedAddr(fixedAddr),
  .gridSeven(gridSeven), .dispEnable(dispEnable)
);

// File: tb/scif_top_tb_top.sv
module scif_top_tb_top;
  localparam int KEY_BYTES = 5;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serDat = 1'b0, serStb = 1'b1;
  logic [KEY_BYTES*8-1:0] keyData = 40'h39_7E_81_C3_5A;
  logic [3:0] dispRdAddr = '0;
  logic [7:0] dispRdData;
  logic serOut, serOutEn, gridSeven, dispEnable, readSel, fixedAddr;
  logic [2:0] dimLevel;
  logic [3:0] curAddr;

  int compared = 0;
  int mismatched = 0;
  logic expQ [$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scif_top dut_i (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serDat(serDat), .serStb(serStb),
    .keyData(keyData), .dispRdAddr(dispRdAddr), .dispRdData(dispRdData),
    .serOut(serOut), .serOutEn(serOutEn), .gridSeven(gridSeven),
    .dispEnable(dispEnable), .dimLevel(dimLevel), .readSel(readSel),
    .fixedAddr(fixedAddr), .curAddr(curAddr)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic openFrame();
    serStb = 1'b0;
    waitClk(HALF);
  endtask

  task automatic closeFrame();
    waitClk(HALF);
    serStb = 1'b1;
    waitClk(8);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      serDat = b[i];
      waitClk(HALF);
      serClk = 1'b1;
      waitClk(HALF);
      serClk = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendBits(b, 8);
  endtask

  task automatic cmd1(input logic [7:0] b);
    openFrame(); sendByte(b); closeFrame();
  endtask

  task automatic memChk(input string req, input logic [3:0] a, input logic [7:0] exp);
    dispRdAddr = a;
    #1;
    chk(req, {24'h0, dispRdData}, {24'h0, exp});
  endtask

  // monitor: pops expected serial read bits after each falling shift edge
  always begin
    @(negedge serClk);
    repeat (5) @(posedge clk);
    #1;
    if (expQ.size() > 0 && serOutEn) begin
      logic e;
      e = expQ.pop_front();
      compared++;
      if (serOut !== e) begin
        mismatched++;
        $display("FAIL R10: serial read bit actual %0b expected %0b", serOut, e);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    waitClk(4);
    rst_n = 1'b1;
    waitClk(4);
    // R1 reset state
    chk("R1 gridSeven", {31'h0, gridSeven}, 1);
    chk("R1 dispEnable", {31'h0, dispEnable}, 0);
    chk("R1 dimLevel", {29'h0, dimLevel}, 0);
    chk("R1 readSel", {31'h0, readSel}, 0);
    chk("R1 fixedAddr", {31'h0, fixedAddr}, 0);
    chk("R1 curAddr", {28'h0, curAddr}, 0);
    chk("R1 serOutEn", {31'h0, serOutEn}, 0);

    // R7 / R2: control command 8Dh, LSB-first assembly
    cmd1(8'h8D);
    chk("R7 R2 on", {31'h0, dispEnable}, 1);
    chk("R7 R2 dim", {29'h0, dimLevel}, 5);

    // R4 repeat current mode (bit0=1), don't-care bits set
    cmd1(8'h03);
    chk("R4 repeat keeps display", {31'h0, dispEnable}, 1);
    chk("R4 repeat keeps grid", {31'h0, gridSeven}, 1);
    // R4 change mode
    cmd1(8'h3C);
    chk("R4 new mode grid", {31'h0, gridSeven}, 0);
    chk("R4 new mode blanks", {31'h0, dispEnable}, 0);

    // R7 off code and reload
    cmd1(8'h8F);
    cmd1(8'h80);
    chk("R7 80h off", {31'h0, dispEnable}, 0);
    chk("R7 80h dim", {29'h0, dimLevel}, 0);
    cmd1(8'h8A);
    chk("R7 on dim2", {29'h0, dimLevel}, 2);

    // R2: clock toggles while strobe high are ignored
    sendByte(8'h80);
    sendByte(8'h80);
    waitClk(8);
    chk("R2 ignored on", {31'h0, dispEnable}, 1);
    chk("R2 ignored dim", {29'h0, dimLevel}, 2);

    // R3: partial byte dropped
    openFrame(); sendBits(8'h80, 5); closeFrame();
    chk("R3 partial on", {31'h0, dispEnable}, 1);
    openFrame(); sendBits(8'h00, 3); closeFrame();
    cmd1(8'h8C);
    chk("R3 realigned dim", {29'h0, dimLevel}, 4);

    // R5 write/increment, ignored bits 5:4
    cmd1(8'h70);
    chk("R5 write", {31'h0, readSel}, 0);
    chk("R5 inc", {31'h0, fixedAddr}, 0);

    // R6 R8 burst from address 0
    openFrame(); sendByte(8'hC0); sendByte(8'h11); sendByte(8'h22); sendByte(8'h33); closeFrame();
    chk("R8 addr after burst", {28'h0, curAddr}, 3);
    memChk("R8 mem0", 4'd0, 8'h11);
    memChk("R8 mem1", 4'd1, 8'h22);
    memChk("R8 mem2", 4'd2, 8'h33);

    // R8 fixed address
    cmd1(8'h44);
    chk("R5 fixed", {31'h0, fixedAddr}, 1);
    openFrame(); sendByte(8'hC9); sendByte(8'hAA); sendByte(8'hBB); closeFrame();
    chk("R6 R8 fixed addr", {28'h0, curAddr}, 9);
    memChk("R8 fixed last", 4'd9, 8'hBB);

    // R9 direct out-of-range address
    cmd1(8'h40);
    openFrame(); sendByte(8'hCE); sendByte(8'h55); closeFrame();
    chk("R9 addr held", {28'h0, curAddr}, 14);
    memChk("R9 no wrap mem0", 4'd0, 8'h11);
    // R9 run off the end
    openFrame(); sendByte(8'hCC); sendByte(8'h01); sendByte(8'h02); sendByte(8'h03); closeFrame();
    chk("R9 stop at 0Eh", {28'h0, curAddr}, 14);
    memChk("R9 mem12", 4'd12, 8'h01);
    memChk("R9 mem13", 4'd13, 8'h02);
    memChk("R9 mem0 intact", 4'd0, 8'h11);
    memChk("R9 mem1 intact", 4'd1, 8'h22);

    // R10 key read of 16 bits
    for (int i = 0; i < 16; i++) expQ.push_back(keyData[i]);
    openFrame();
    sendByte(8'h42);
    chk("R5 read", {31'h0, readSel}, 1);
    chk("R10 oe in read", {31'h0, serOutEn}, 1);
    sendBits(8'hFF, 8);
    sendBits(8'hFF, 8);
    closeFrame();
    chk("R10 all bits popped", expQ.size(), 0);
    chk("R10 oe after strobe", {31'h0, serOutEn}, 0);
    memChk("R10 din ignored", 4'd0, 8'h11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule